// File: doc/BRIEF.md
# Hall-Edge Tachometer and Direction Detector

This block watches the three Hall sensor bits of a brushless motor, already brought into the clock domain. Any change of those bits counts as a commutation event. Each event starts a retriggerable one-shot whose on-time is set in clock cycles by an input word. The pulse train that results has a frequency proportional to rotor speed. The pulse runs whatever the drive state is, including braking.

The block also measures the actual direction of rotation. The six valid sensor codes form a fixed ring, and each code has exactly two legal neighbours, one per direction. Every transition is checked against that ring. A forward step makes the measured direction equal the commanded direction bit. A backward step makes it the inverse. Invalid codes and jumps between codes that are not neighbours leave the output as it was.

Top module: `hall_tach_dir`

## Requirements
- R1: While reset is asserted, and after it, tach_o and dir_o are 0. The sensor value sampled in the first cycle after reset is taken as the starting state and does not start a pulse.
- R2: A change in any of the three hall_i bits, in either direction, raises tach_o at the next clock edge.
- R3: After a change with no further change, tach_o stays high for exactly pulse_len_i+1 cycles and then falls. A length of 0 gives a single-cycle pulse. With no changes, tach_o stays low.
- R4: A change that arrives while tach_o is high reloads the full on-time from pulse_len_i at that clock edge. The pulse then lasts pulse_len_i+1 cycles counted from that change.
- R5: The forward ring is 101 -> 100 -> 110 -> 010 -> 011 -> 001 -> 101, written {hall_i[2],hall_i[1],hall_i[0]}. A step one place forward sets dir_o to the value dir_cmd_i had in that cycle. The new value appears at the next clock edge.
- R6: A step one place backward on the same ring sets dir_o to the inverse of dir_cmd_i at the next clock edge.
- R7: A transition into or out of 000 or 111, or a jump between codes that are not neighbours on the ring, leaves dir_o unchanged, and it still starts a pulse.
- R8: A change of dir_cmd_i with no change of hall_i leaves dir_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_i | input | 3 | Synchronized Hall sensor bits |
| pulse_len_i | input | PULSE_W | Pulse on-time minus one, in cycles |
| dir_cmd_i | input | 1 | Commanded direction, the reference polarity |
| tach_o | output | 1 | Tachometer pulse |
| dir_o | output | 1 | Measured rotation direction |

## Verification
Both results are due exactly one clock edge after the cycle in which hall_i changes. That edge raises tach_o and loads the new dir_o. tach_o then holds for pulse_len_i further cycles.

The driver applies one set of inputs per cycle on the falling edge. For every cycle it computes the expected pair from the requirements and queues it. The monitor takes one entry after each rising edge, once the registers have settled, so each item is compared in exactly the cycle it is due.

// File: rtl/hall_tach_pkg.sv
package hall_tach_pkg;
  typedef enum logic [1:0] {STEP_NONE, STEP_FWD, STEP_REV} step_e;

  localparam logic [2:0] POS_BAD = 3'd7;

  // Place of a sensor code on the forward ring, POS_BAD for 000/111.
  function automatic logic [2:0] hall_pos(input logic [2:0] h);
    logic [2:0] p;
    case (h)
      3'b101:  p = 3'd0;
      3'b100:  p = 3'd1;
      3'b110:  p = 3'd2;
      3'b010:  p = 3'd3;
      3'b011:  p = 3'd4;
      3'b001:  p = 3'd5;
      default: p = POS_BAD;
    endcase
    return p;
  endfunction

  // Classify a transition from code a to code b.
  function automatic step_e classify(input logic [2:0] a, input logic [2:0] b);
    logic [2:0] pa, pb, nxt, prv;
    step_e s;
    pa  = hall_pos(a);
    pb  = hall_pos(b);
    nxt = (pa == 3'd5) ? 3'd0 : pa + 3'd1;
    prv = (pa == 3'd0) ? 3'd5 : pa - 3'd1;
    if (pa == POS_BAD || pb == POS_BAD) s = STEP_NONE;
    else if (pb == nxt)                 s = STEP_FWD;
    else if (pb == prv)                 s = STEP_REV;
    else                                s = STEP_NONE;
    return s;
  endfunction
endpackage

// File: rtl/hall_edge_det.sv
module hall_edge_det (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_i,
  output logic [2:0] hall_prev_o,
  output logic       edge_o
);
  logic prev_vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hall_prev_o <= 3'b000;
      prev_vld_q  <= 1'b0;
    end else begin
      hall_prev_o <= hall_i;
      prev_vld_q  <= 1'b1;
    end
  end

  assign edge_o = prev_vld_q && (hall_i != hall_prev_o);
endmodule

// File: rtl/tach_oneshot.sv
module tach_oneshot #(
  parameter int PULSE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_i,
  input  logic [PULSE_W-1:0] len_i,
  output logic               tach_o,
  output logic [PULSE_W-1:0] remain_o
);
  localparam logic [PULSE_W-1:0] ZERO = '0;
  localparam logic [PULSE_W-1:0] ONE  = {{(PULSE_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tach_o   <= 1'b0;
      remain_o <= ZERO;
    end else if (trig_i) begin
      tach_o   <= 1'b1;
      remain_o <= len_i;
    end else if (tach_o) begin
      if (remain_o == ZERO) tach_o <= 1'b0;
      else                  remain_o <= remain_o - ONE;
    end
  end
endmodule

// File: rtl/dir_tracker.sv
module dir_tracker
  import hall_tach_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_prev_i,
  input  logic [2:0] hall_now_i,
  input  logic       edge_i,
  input  logic       cmd_i,
  output step_e      step_o,
  output logic       dir_o
);
  assign step_o = edge_i ? classify(hall_prev_i, hall_now_i) : STEP_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  dir_o <= 1'b0;
    else if (step_o == STEP_FWD) dir_o <= cmd_i;
    else if (step_o == STEP_REV) dir_o <= ~cmd_i;
  end
endmodule

// File: rtl/hall_tach_dir.sv
module hall_tach_dir
  import hall_tach_pkg::*;
#(
  parameter int PULSE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         hall_i,
  input  logic [PULSE_W-1:0] pulse_len_i,
  input  logic               dir_cmd_i,
  output logic               tach_o,
  output logic               dir_o
);
  logic [2:0]         hall_prev_w;
  logic               edge_w;
  logic [PULSE_W-1:0] remain_w;
  step_e              step_w;
  logic               step_fwd;
  logic               step_rev;

  hall_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .hall_i(hall_i),
    .hall_prev_o(hall_prev_w), .edge_o(edge_w)
  );

  tach_oneshot #(.PULSE_W(PULSE_W)) u_shot (
    .clk(clk), .rst_n(rst_n), .trig_i(edge_w), .len_i(pulse_len_i),
    .tach_o(tach_o), .remain_o(remain_w)
  );

  dir_tracker u_dir (
    .clk(clk), .rst_n(rst_n), .hall_prev_i(hall_prev_w), .hall_now_i(hall_i),
    .edge_i(edge_w), .cmd_i(dir_cmd_i), .step_o(step_w), .dir_o(dir_o)
  );

  assign step_fwd = (step_w == STEP_FWD);
  assign step_rev = (step_w == STEP_REV);
endmodule

// File: rtl/hall_tach_dir_chk.sv
module hall_tach_dir_chk #(
  parameter int PULSE_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               edge_w,
  input logic               tach_o,
  input logic [PULSE_W-1:0] remain_w,
  input logic [PULSE_W-1:0] pulse_len_i,
  input logic               step_fwd,
  input logic               step_rev,
  input logic               dir_o,
  input logic               dir_cmd_i
);
  AST_EDGE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    edge_w |=> tach_o); // R2
  AST_EDGE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    edge_w |=> remain_w == $past(pulse_len_i)); // R4
  AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tach_o && !edge_w && remain_w == '0) |=> !tach_o); // R3
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!tach_o && !edge_w) |=> !tach_o); // R3
  AST_FWD_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    step_fwd |=> dir_o == $past(dir_cmd_i)); // R5
  AST_REV_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    step_rev |=> dir_o != $past(dir_cmd_i)); // R6
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_fwd && !step_rev) |=> $stable(dir_o)); // R7
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({step_fwd, step_rev}) <= 1 && ((step_fwd || step_rev) -> edge_w)); // R8
endmodule

bind hall_tach_dir hall_tach_dir_chk #(.PULSE_W(PULSE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .edge_w(edge_w), .tach_o(tach_o),
  .remain_w(remain_w), .pulse_len_i(pulse_len_i), .step_fwd(step_fwd),
  .step_rev(step_rev), .dir_o(dir_o), .dir_cmd_i(dir_cmd_i)
);

// File: tb/hall_tach_dir_tb_top.sv
module hall_tach_dir_tb_top;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    hall = 3'b101;
  logic [PW-1:0] plen = '0;
  logic          cmd = 1'b0;
  logic          tach_o, dir_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  logic [2:0] m_prev = 3'b101;
  int         m_hi   = 0;
  logic       m_dir  = 1'b0;

  logic [1:0] q_exp[$];
  string      q_req[$];

  always #10 clk = ~clk;

  hall_tach_dir #(.PULSE_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .hall_i(hall), .pulse_len_i(plen),
    .dir_cmd_i(cmd), .tach_o(tach_o), .dir_o(dir_o)
  );

  function automatic int ring_idx(input logic [2:0] h);
    logic [2:0] ring [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
    for (int i = 0; i < 6; i++) if (ring[i] == h) return i;
    return -1;
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {tach,dir} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // driver: one cycle of stimulus plus the expected result one edge later
  task automatic cyc(input logic [2:0] h, input int len, input logic c, input string req);
    int pa, pb;
    logic t;
    @(negedge clk);
    hall = h; plen = PW'(len); cmd = c;
    if (h != m_prev) begin
      m_hi = len + 1;
      pa = ring_idx(m_prev);
      pb = ring_idx(h);
      if (pa >= 0 && pb >= 0) begin
        if (pb == (pa + 1) % 6)      m_dir = c;
        else if (pb == (pa + 5) % 6) m_dir = ~c;
      end
    end
    m_prev = h;
    t = (m_hi > 0);
    if (m_hi > 0) m_hi--;
    q_exp.push_back({t, m_dir});
    q_req.push_back(req);
  endtask

  task automatic hold(input int n, input int len, input logic c, input string req);
    for (int i = 0; i < n; i++) cyc(m_prev, len, c, req);
  endtask

  // monitor
  always begin
    @(posedge clk);
    #5;
    if (q_exp.size() > 0) check(q_req.pop_front(), {tach_o, dir_o}, q_exp.pop_front());
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {tach_o, dir_o}, 2'b00);
    rst_n = 1'b1;
    hold(4, 3, 1'b1, "R1");              // start code taken, no pulse
    // R2, R3, R5: forward steps, width 3
    cyc(3'b100, 3, 1'b1, "R5");
    hold(6, 3, 1'b1, "R3");
    cyc(3'b110, 3, 1'b1, "R2");
    hold(6, 3, 1'b1, "R3");
    // R6: backward step
    cyc(3'b100, 3, 1'b1, "R6");
    hold(5, 3, 1'b1, "R3");
    // R3: width 0
    cyc(3'b101, 0, 1'b0, "R6");
    hold(3, 0, 1'b0, "R3");
    cyc(3'b100, 0, 1'b0, "R5");
    hold(2, 0, 1'b0, "R3");
    // R4: retrigger during on-time
    cyc(3'b110, 5, 1'b1, "R4");
    hold(2, 5, 1'b1, "R4");
    cyc(3'b010, 5, 1'b1, "R4");
    hold(1, 5, 1'b1, "R4");
    cyc(3'b011, 5, 1'b1, "R4");
    hold(8, 5, 1'b1, "R4");
    // R7: invalid codes and a non-adjacent jump
    cyc(3'b111, 2, 1'b0, "R7");
    hold(4, 2, 1'b0, "R7");
    cyc(3'b001, 2, 1'b0, "R7");
    hold(4, 2, 1'b0, "R7");
    cyc(3'b010, 2, 1'b0, "R7");          // 001 -> 010 skips a place
    hold(4, 2, 1'b0, "R7");
    cyc(3'b000, 2, 1'b0, "R7");
    hold(4, 2, 1'b0, "R7");
    cyc(3'b110, 2, 1'b0, "R7");
    hold(4, 2, 1'b0, "R7");
    // R8: command toggles alone
    hold(3, 2, 1'b1, "R8");
    hold(3, 2, 1'b0, "R8");
    cyc(3'b010, 2, 1'b0, "R5");          // forward with command 0
    hold(4, 2, 1'b1, "R8");
    cyc(3'b110, 2, 1'b1, "R6");
    hold(4, 2, 1'b1, "R3");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule